// File: doc/BRIEF.md
# Chained Stage Self-Test Sequencer

This block sits in one stage of a stack of identical monitor devices and runs that stage's part of a chain-wide self-test. A fast system clock samples three slow chain inputs: a test clock, a test-hold level and a chip-active level from the stage above. While the hold level is high the stage works normally. When it drops, the stage counts test clock cycles. Over the first five cycles it pulses one stimulus enable per cycle. It also steps a detection-delay mode code through a short sequence.

The stage keeps the stage above it in hold until its own eight-cycle test has finished. It then passes the test clock upward. The chip-active output rises on the first test cycle and falls at the end of the eighth. After that it copies the chip-active input from the stage above, one test cycle later each time. Because each stage adds one cycle of delay, the device at the bottom of the stack can tell which stage is testing by counting cycles on its chip-active output. The current sources, comparators and the real delay timer are outside this block. It only drives digital enables and a mode code.

Top module: `chain_selftest`

## Requirements
- R1: Whenever the synchronized hold input is high, the outputs take their normal-operation values: hold_out=1, tclk_out=1, act_out=0, stim_en=0 and dly_mode=2'b00. Toggling tclk_in during this time changes none of them.
- R2: When hold_in goes low, tclk_out is driven low and dly_mode becomes 2'b10 (slow). hold_out stays high and act_out stays low until the first test clock rise.
- R3: hold_out goes low on the falling edge of the 8th test clock cycle and stays low for as long as the test continues.
- R4: From the 9th test clock cycle onward, tclk_out goes high on each tclk_in rise and low on each tclk_in fall. Before that it is low.
- R5: act_out goes high on the 1st test clock rise after release and low on the falling edge of the 8th cycle.
- R6: From the 9th cycle onward, act_out takes the value of act_in sampled at each test clock rise and holds it until the next rise.
- R7: stim_en bit k (k=0..4) is high from the rise to the fall of test cycle k+1, and is low at all other times. Bit 0 is tap 2 low side, bit 1 is tap 3 low side, bit 2 is tap 3 high side, bit 3 is tap 4 high side and bit 4 is tap 5 high side.
- R8: dly_mode is 2'b01 (fast) from the 1st rise until the 7th rise. It is 2'b10 from the 7th rise until the 8th fall, and 2'b00 from then on. The code 2'b11 never appears.
- R9: The cycle count saturates at 9, so the pass-through behaviour of R4 and R6 continues unchanged through any number of cycles.
- R10: A test clock edge that is synchronized on the same system cycle as the hold input going high is ignored. All outputs return to their R1 values.
- R11: After an abort part-way through a test, a new release restarts the sequence from cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the test clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tclk_in | input | 1 | Test clock from the stage below (asynchronous) |
| hold_in | input | 1 | Test-hold level from the stage below; high means normal operation |
| act_in | input | 1 | Chip-active level from the stage above |
| hold_out | output | 1 | Test-hold level to the stage above |
| tclk_out | output | 1 | Test clock to the stage above |
| act_out | output | 1 | Chip-active level to the stage below |
| stim_en | output | 5 | One-hot stimulus enables for test cycles 1 to 5 |
| dly_mode | output | 2 | Delay mode: 00 normal, 01 fast, 10 slow |

## Verification
Every input change passes through two synchronizer flops. Edge detection is combinational on the second flop, and all outputs are registered on the next edge. As a result, each output reflects an input change on the third system clock edge after it. The bench changes inputs on a falling clock edge and holds every test clock phase for six system cycles. It samples outputs on a falling edge four cycles after the change, so every result has settled and none is read in the cycle it updates. The coincident-edge case is checked by switching hold_in and tclk_in on the same edge, so they pass through the synchronizer together.

// File: rtl/st_pkg.sv
// Package: st_pkg
// Shared types for the chained self-test sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package st_pkg;

    // Delay-mode code driven to the detection timer.
    typedef enum logic [1:0] {
        DLY_NORMAL = 2'b00,
        DLY_FAST   = 2'b01,
        DLY_SLOW   = 2'b10
    } dly_mode_e;

endpackage

// File: rtl/st_sync.sv
// Module: st_sync
// Multi-bit chain of flops that brings asynchronous levels into the clk domain.
// Assumes: each bit is an independent slow level; no bus coherency needed.
module st_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/st_counter.sv
// Module: st_counter
// Finds test clock edges and counts test clock rises since the hold input dropped.
// Assumes: inputs already synchronized; count saturates at TEST_CYCLES+1.
module st_counter #(
    parameter int TEST_CYCLES = 8,
    localparam int SAT        = TEST_CYCLES + 1,
    localparam int CNT_W      = $clog2(SAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tclk_s,
    input  logic             hold_s,
    output logic             tc_rise,
    output logic             tc_fall,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);

    logic tclk_d;
    logic [CNT_W-1:0] cnt_q;

    // Remember the synchronized test clock one system cycle back.
    always_ff @(posedge clk) begin
        if (!rst_n) tclk_d <= 1'b0;
        else        tclk_d <= tclk_s;
    end

    assign tc_rise = tclk_s & ~tclk_d;
    assign tc_fall = ~tclk_s & tclk_d;

    // Count test clock rises while in test; clear while held.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (hold_s)                       cnt_q <= '0;
        else if (tc_rise && (cnt_q != SAT_C))  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R9
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_C);

    // R9
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_C && !hold_s) |=> (cnt_q == SAT_C));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> (cnt_q == '0));

endmodule

// File: rtl/st_chain_drv.sv
// Module: st_chain_drv
// Drives the hold, test clock and chip-active outputs toward neighbouring stages.
// Assumes: edge pulses and count come from st_counter; count holds pre-edge value.
module st_chain_drv #(
    parameter int TEST_CYCLES = 8,
    localparam int SAT        = TEST_CYCLES + 1,
    localparam int CNT_W      = $clog2(SAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_s,
    input  logic             act_s,
    input  logic             tc_rise,
    input  logic             tc_fall,
    input  logic [CNT_W-1:0] cnt,
    output logic             hold_out,
    output logic             tclk_out,
    output logic             act_out
);

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TEST_CYCLES);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT);

    logic hold_q, tclk_q, act_q;

    // Release the stage above at the end of this stage's last test cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_q <= 1'b1;
        else if (hold_s)                    hold_q <= 1'b1;
        else if (tc_fall && cnt == LAST_C)  hold_q <= 1'b0;
    end

    // Keep the upward clock low during the test, then pass it through.
    always_ff @(posedge clk) begin
        if (!rst_n)             tclk_q <= 1'b1;
        else if (hold_s)        tclk_q <= 1'b1;
        else if (tc_rise)       tclk_q <= (cnt >= LAST_C);
        else if (tc_fall)       tclk_q <= 1'b0;
        else if (cnt != SAT_C)  tclk_q <= 1'b0;
    end

    // Flag own test for eight cycles, then relay the flag from above.
    always_ff @(posedge clk) begin
        if (!rst_n)                         act_q <= 1'b0;
        else if (hold_s)                    act_q <= 1'b0;
        else if (tc_rise)                   act_q <= (cnt >= LAST_C) ? act_s : 1'b1;
        else if (tc_fall && cnt == LAST_C)  act_q <= 1'b0;
    end

    assign hold_out = hold_q;
    assign tclk_out = tclk_q;
    assign act_out  = act_q;

    // R1
    hold_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> (hold_q && tclk_q && !act_q));

    // R3
    hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> ($past(tc_fall) && $past(cnt) == LAST_C));

    // R4
    tclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tclk_q) |-> ($past(hold_s) || $past(tc_rise)));

    // R5
    act_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && tc_rise && cnt == '0) |=> act_q);

endmodule

// File: rtl/st_phase_dec.sv
// Module: st_phase_dec
// Decodes the test phase into stimulus enables and the delay-mode code.
// Assumes: NUM_STIM <= TEST_CYCLES - 2; count holds its pre-edge value.
module st_phase_dec
    import st_pkg::*;
#(
    parameter int TEST_CYCLES = 8,
    parameter int NUM_STIM    = 5,
    localparam int SAT        = TEST_CYCLES + 1,
    localparam int CNT_W      = $clog2(SAT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_s,
    input  logic                tc_rise,
    input  logic                tc_fall,
    input  logic [CNT_W-1:0]    cnt,
    output logic [NUM_STIM-1:0] stim_en,
    output dly_mode_e           dly_mode
);

    localparam logic [CNT_W-1:0] LAST_C     = CNT_W'(TEST_CYCLES);
    localparam logic [CNT_W-1:0] FAST_END_C = CNT_W'(TEST_CYCLES - 2);

    logic [NUM_STIM-1:0] stim_q;
    dly_mode_e           mode_q;

    for (genvar k = 0; k < NUM_STIM; k++) begin : g_stim
        // Enable stimulus k for the high phase of test cycle k+1.
        always_ff @(posedge clk) begin
            if (!rst_n)        stim_q[k] <= 1'b0;
            else if (hold_s)   stim_q[k] <= 1'b0;
            else if (tc_rise)  stim_q[k] <= (cnt == CNT_W'(k));
            else if (tc_fall)  stim_q[k] <= 1'b0;
        end
    end

    // Step the delay mode through slow, fast, slow, normal.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= DLY_NORMAL;
        else if (hold_s)                         mode_q <= DLY_NORMAL;
        else if (tc_rise && cnt == '0)           mode_q <= DLY_FAST;
        else if (tc_rise && cnt == FAST_END_C)   mode_q <= DLY_SLOW;
        else if (tc_fall && cnt == LAST_C)       mode_q <= DLY_NORMAL;
        else if (cnt == '0)                      mode_q <= DLY_SLOW;
    end

    assign stim_en  = stim_q;
    assign dly_mode = mode_q;

    // R7
    stim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stim_q));

    // R8
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b11);

    // R8
    mode_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && tc_rise && cnt == '0) |=> (mode_q == DLY_FAST));

endmodule

// File: rtl/chain_selftest.sv
// Module: chain_selftest
// One stage of a chained self-test: synchronizes chain inputs, counts test cycles,
// drives neighbour signals, stimulus enables and delay mode.
// Assumes: test clock phases last several system clock cycles.
module chain_selftest
    import st_pkg::*;
#(
    parameter int TEST_CYCLES = 8,
    parameter int NUM_STIM    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tclk_in,
    input  logic                hold_in,
    input  logic                act_in,
    output logic                hold_out,
    output logic                tclk_out,
    output logic                act_out,
    output logic [NUM_STIM-1:0] stim_en,
    output logic [1:0]          dly_mode
);

    localparam int SAT   = TEST_CYCLES + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [2:0]       sync_q;
    logic             tclk_s, hold_s, act_s;
    logic             tc_rise, tc_fall;
    logic [CNT_W-1:0] cnt;
    dly_mode_e        mode;

    st_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({act_in, hold_in, tclk_in}),
        .q_sync  (sync_q)
    );

    assign tclk_s = sync_q[0];
    assign hold_s = sync_q[1];
    assign act_s  = sync_q[2];

    st_counter #(.TEST_CYCLES(TEST_CYCLES)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tclk_s  (tclk_s),
        .hold_s  (hold_s),
        .tc_rise (tc_rise),
        .tc_fall (tc_fall),
        .cnt     (cnt)
    );

    st_chain_drv #(.TEST_CYCLES(TEST_CYCLES)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_s   (hold_s),
        .act_s    (act_s),
        .tc_rise  (tc_rise),
        .tc_fall  (tc_fall),
        .cnt      (cnt),
        .hold_out (hold_out),
        .tclk_out (tclk_out),
        .act_out  (act_out)
    );

    st_phase_dec #(
        .TEST_CYCLES (TEST_CYCLES),
        .NUM_STIM    (NUM_STIM)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_s   (hold_s),
        .tc_rise  (tc_rise),
        .tc_fall  (tc_fall),
        .cnt      (cnt),
        .stim_en  (stim_en),
        .dly_mode (mode)
    );

    assign dly_mode = mode;

endmodule

// File: tb/chain_selftest_bench.sv
`timescale 1ns/1ps
module chain_selftest_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk_in = 1'b0;
    logic       hold_in = 1'b1;
    logic       act_in = 1'b0;
    logic       hold_out, tclk_out, act_out;
    logic [4:0] stim_en;
    logic [1:0] dly_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chain_selftest u_chain_selftest (
        .clk      (clk),
        .rst_n    (rst_n),
        .tclk_in  (tclk_in),
        .hold_in  (hold_in),
        .act_in   (act_in),
        .hold_out (hold_out),
        .tclk_out (tclk_out),
        .act_out  (act_out),
        .stim_en  (stim_en),
        .dly_mode (dly_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_normal(input string req);
        check(req, "hold_out", hold_out, 1);
        check(req, "tclk_out", tclk_out, 1);
        check(req, "act_out",  act_out,  0);
        check(req, "stim_en",  stim_en,  0);
        check(req, "dly_mode", dly_mode, 2'b00);
    endtask

    // One test clock cycle n; checks high phase then low phase.
    task automatic pulse(input int n, input bit ain, input string stag);
        logic [4:0] exp_stim;
        logic [1:0] exp_mode;
        act_in = ain;
        tick(6);
        tclk_in = 1'b1;
        tick(6);
        exp_stim = (n <= 5) ? 5'(1 << (n - 1)) : 5'd0;
        exp_mode = (n <= 6) ? 2'b01 : (n <= 8) ? 2'b10 : 2'b00;
        check(stag, $sformatf("stim_en hi c%0d", n), stim_en, exp_stim);
        check("R8", $sformatf("dly_mode hi c%0d", n), dly_mode, exp_mode);
        check("R3", $sformatf("hold_out hi c%0d", n), hold_out, (n <= 8) ? 1 : 0);
        check((n >= 12) ? "R9" : "R4", $sformatf("tclk_out hi c%0d", n),
              tclk_out, (n >= 9) ? 1 : 0);
        if (n <= 8) check("R5", $sformatf("act_out hi c%0d", n), act_out, 1);
        else        check("R6", $sformatf("act_out hi c%0d", n), act_out, ain);
        tclk_in = 1'b0;
        act_in = ~ain;
        tick(6);
        exp_mode = (n <= 6) ? 2'b01 : (n == 7) ? 2'b10 : 2'b00;
        check("R7", $sformatf("stim_en lo c%0d", n), stim_en, 0);
        check("R8", $sformatf("dly_mode lo c%0d", n), dly_mode, exp_mode);
        check("R3", $sformatf("hold_out lo c%0d", n), hold_out, (n >= 8) ? 0 : 1);
        check("R4", $sformatf("tclk_out lo c%0d", n), tclk_out, 0);
        if (n < 8)       check("R5", $sformatf("act_out lo c%0d", n), act_out, 1);
        else if (n == 8) check("R5", "act_out lo c8", act_out, 0);
        else             check("R6", $sformatf("act_out lo c%0d", n), act_out, ain);
    endtask

    task automatic release_hold();
        hold_in = 1'b0;
        tick(4);
        check("R2", "tclk_out", tclk_out, 0);
        check("R2", "hold_out", hold_out, 1);
        check("R2", "act_out",  act_out,  0);
        check("R2", "dly_mode", dly_mode, 2'b10);
        check("R2", "stim_en",  stim_en,  0);
    endtask

    task automatic t_reset_state();
        check_normal("R1");
    endtask

    task automatic t_idle_toggle();
        for (int i = 0; i < 4; i++) begin
            tclk_in = ~tclk_in;
            tick(6);
            check_normal("R1");
        end
        tclk_in = 1'b0;
        tick(6);
    endtask

    task automatic t_full_run();
        release_hold();
        for (int n = 1; n <= 20; n++)
            pulse(n, (n == 10) || (n == 11) || (n == 15), "R7");
    endtask

    task automatic t_coincident_edge();
        hold_in = 1'b1;
        tclk_in = 1'b1;
        tick(4);
        check_normal("R10");
        tclk_in = 1'b0;
        tick(6);
        check_normal("R10");
    endtask

    task automatic t_abort_restart();
        release_hold();
        for (int n = 1; n <= 3; n++) pulse(n, 1'b0, "R7");
        tclk_in = 1'b1;
        tick(6);
        t_coincident_edge();
        release_hold();
        for (int n = 1; n <= 10; n++) pulse(n, n == 9, "R11");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset_state();
        t_idle_toggle();
        t_full_run();
        t_coincident_edge();
        t_abort_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule